// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 9-bit words between a write clock and a read clock. The two clocks may be unrelated, or tied to one clock. The write and read pointers each live in their own clock domain. Each pointer reaches the other domain as Gray code through a two-stage synchronizer. Four active-low status flags are derived from the pointers: empty, almost-empty, almost-full and full. Empty and almost-empty are produced on the read clock. Full and almost-full are produced on the write clock. The read port has a registered output that can be switched to high impedance.

The streams follow valid/ready rules expressed with active-low enables. On the write side the enables act as valid and `full_n` acts as ready. A word enters only on a write-clock edge where the enables request a write and `full_n` is high. A request made while `full_n` is low is dropped; it is not queued. On the read side `empty_n` acts as valid and the two read enables act as ready. A word leaves on a read-clock edge where both enables are low and `empty_n` is high. A producer must keep its data stable and its enables asserted until it sees `full_n` high at the edge.

The `wen2_ld` pin takes one of two roles, fixed by its level while reset is held low:
- **High during reset:** the pin is a second write qualifier.
- **Low during reset:** the pin is a load strobe for the two threshold offsets. Each offset is 18 bits, written and read back as two 9-bit halves in a fixed cyclic order.

Both thresholds default to 7 after reset. The read domain uses the offset registers as quasi-static values, so software changes them only while traffic is idle.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst_n` is low, both pointers return to location zero, `empty_n` and `almost_empty_n` go low, `full_n` and `almost_full_n` go high, and the output register clears to 0.
- R2: Words leave in the order they were accepted. A read on a read-clock edge places the oldest stored word on `rd_data` after that edge.
- R3: If `wen2_ld` is high during reset (qualifier mode), a word is written only when `wr_en_n` is low and `wen2_ld` is high. Either enable inactive leaves the FIFO unchanged.
- R4: If `wen2_ld` is low during reset (load mode), a word is written when `wr_en_n` is low while `wen2_ld` is high.
- R5: A read happens only when `rd_en_a_n` and `rd_en_b_n` are both low. A single low enable neither moves data nor changes `rd_data`.
- R6: Write requests are dropped while `full_n` is low, and read requests are dropped while `empty_n` is low. The buffer never holds more than DEPTH words.
- R7: A pointer advances one Gray step per transfer. A write accepted at write-clock edge k makes `empty_n` rise at read-clock edge k+2 when the clocks are tied.
- R8: With default offsets, `almost_empty_n` is low while 7 or fewer words are stored. `almost_full_n` is low while 7 or fewer free slots remain.
- R9: In load mode, each write-clock edge with `wr_en_n` low and `wen2_ld` low stores `wr_data` into the next offset slot. The slot order cycles 0..3 and wraps:
  - slot 0: almost-empty offset bits 8:0
  - slot 1: almost-empty offset bits 17:9
  - slot 2: almost-full offset bits 8:0
  - slot 3: almost-full offset bits 17:9

  After loading, `almost_empty_n` is low while the count is at most the almost-empty offset, and `almost_full_n` is low while the free count is at most the almost-full offset.
- R10: In load mode, each read-clock edge with both read enables low and `wen2_ld` low loads the next offset slot onto `rd_data`, in the same cyclic order as R9. FIFO contents are not consumed.
- R11: With `oe_n` high, `rd_data_oe` is low and `rd_data` is high impedance. With `oe_n` low, `rd_data_oe` is high and `rd_data` carries the output register.
- R12: The output register changes only on an accepted read or an offset read-back, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_data | input | 9 | Write data, or offset half in load mode |
| wr_en_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | Second write qualifier or offset load strobe, role fixed during reset |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| almost_full_n | output | 1 | Almost-full flag, active low, write-clock domain |
| rd_clk | input | 1 | Read clock |
| rd_en_a_n | input | 1 | Read enable A, active low |
| rd_en_b_n | input | 1 | Read enable B, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | 9 | Registered read data, high impedance when disabled |
| rd_data_oe | output | 1 | High while `rd_data` is driven |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read-clock domain |
| rst_n | input | 1 | Asynchronous reset, active low, shared by both domains |

## Verification
A corrupted write pointer or memory location shows up at the first read that reaches it: `rd_data` disagrees with the stored order on the edge after that read. A wrong count or synchronizer stage shows in the flags. Either a flag fails to settle to its expected level within three idle cycles of the opposite clock, or `full_n`/`empty_n` stays high when the buffer is truly full or empty; the latter is caught at the very next request. A broken offset sequencer shows at the first read-back as a half in the wrong slot, and again as a threshold crossing one count away from where it should be.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int unsigned DATA_W = 9;
  localparam int unsigned OFS_W  = 2 * DATA_W;
  localparam int unsigned OFS_RESET = 7;

  typedef enum logic [1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } ofs_slot_e;

  function automatic logic [DATA_W-1:0] slot_value(
    input ofs_slot_e slot,
    input logic [OFS_W-1:0] ae,
    input logic [OFS_W-1:0] af
  );
    case (slot)
      SLOT_AE_LO: slot_value = ae[DATA_W-1:0];
      SLOT_AE_HI: slot_value = ae[OFS_W-1:DATA_W];
      SLOT_AF_LO: slot_value = af[DATA_W-1:0];
      default:    slot_value = af[OFS_W-1:DATA_W];
    endcase
  endfunction
endpackage

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo_gsync.sv
module dcfifo_gsync #(
  parameter int unsigned W = 9
) (
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  assign bin_out[W-1] = stage2[W-1];
  for (genvar i = W - 2; i >= 0; i--) begin : g_g2b
    assign bin_out[i] = bin_out[i+1] ^ stage2[i];
  end
endmodule

// File: rtl/dcfifo_ofs.sv
module dcfifo_ofs
  import dcfifo_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  localparam int unsigned OW = 2 * DW
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          load_fire,
  input  logic [DW-1:0] wr_data,
  output logic [OW-1:0] ae_ofs,
  output logic [OW-1:0] af_ofs
);
  ofs_slot_e slot;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= SLOT_AE_LO;
      ae_ofs <= OW'(OFS_RESET);
      af_ofs <= OW'(OFS_RESET);
    end else if (load_fire) begin
      case (slot)
        SLOT_AE_LO: ae_ofs[DW-1:0]  <= wr_data;
        SLOT_AE_HI: ae_ofs[OW-1:DW] <= wr_data;
        SLOT_AF_LO: af_ofs[DW-1:0]  <= wr_data;
        default:    af_ofs[OW-1:DW] <= wr_data;
      endcase
      slot <= ofs_slot_e'(slot + 2'd1);
    end
  end

  AST_LOAD_ADVANCES: assert property (@(posedge wr_clk) disable iff (!rst_n)
    load_fire |=> (slot != $past(slot))); // R9
endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned OW    = 18,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          wen2_ld,
  input  logic [PW-1:0] rptr_sync,
  input  logic [OW-1:0] af_ofs,
  output logic          load_mode,
  output logic          wr_fire,
  output logic          load_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wptr_gray,
  output logic          full_n,
  output logic          almost_full_n
);
  logic [PW-1:0] wptr_bin, wptr_inc, used;
  logic [31:0]   free_slots;

  always_ff @(posedge wr_clk) begin
    if (!rst_n) load_mode <= ~wen2_ld;
  end

  assign wptr_inc  = wptr_bin + PW'(1);
  assign used      = wptr_bin - rptr_sync;
  assign free_slots = 32'(DEPTH) - 32'(used);
  assign full_n        = (used != PW'(DEPTH));
  assign almost_full_n = (free_slots > 32'(af_ofs));
  assign wr_fire   = !wr_en_n && wen2_ld && full_n;
  assign load_fire = load_mode && !wr_en_n && !wen2_ld;
  assign waddr     = wptr_bin[AW-1:0];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (wr_fire) begin
      wptr_bin  <= wptr_inc;
      wptr_gray <= wptr_inc ^ (wptr_inc >> 1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    32'(used) <= 32'(DEPTH)); // R6
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wptr_bin)); // R6
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $onehot0(wptr_gray ^ $past(wptr_gray))); // R7
endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
  import dcfifo_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1,
  localparam int unsigned OW   = 2 * DW
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          wen2_ld,
  input  logic [PW-1:0] wptr_sync,
  input  logic [DW-1:0] ram_q,
  input  logic [OW-1:0] ae_ofs,
  input  logic [OW-1:0] af_ofs,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rptr_gray,
  output logic [DW-1:0] dout_q,
  output logic          empty_n,
  output logic          almost_empty_n
);
  logic          load_mode, both_en, rd_fire, rb_fire;
  logic [PW-1:0] rptr_bin, rptr_inc, used;
  ofs_slot_e     rb_slot;

  always_ff @(posedge rd_clk) begin
    if (!rst_n) load_mode <= ~wen2_ld;
  end

  assign both_en  = !rd_en_a_n && !rd_en_b_n;
  assign rb_fire  = load_mode && !wen2_ld && both_en;
  assign used     = wptr_sync - rptr_bin;
  assign empty_n  = (used != '0);
  assign almost_empty_n = (32'(used) > 32'(ae_ofs));
  assign rd_fire  = both_en && !rb_fire && empty_n;
  assign rptr_inc = rptr_bin + PW'(1);
  assign raddr    = rptr_bin[AW-1:0];

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      dout_q    <= '0;
      rb_slot   <= SLOT_AE_LO;
    end else if (rd_fire) begin
      rptr_bin  <= rptr_inc;
      rptr_gray <= rptr_inc ^ (rptr_inc >> 1);
      dout_q    <= ram_q;
    end else if (rb_fire) begin
      dout_q  <= slot_value(rb_slot, ae_ofs, af_ofs);
      rb_slot <= ofs_slot_e'(rb_slot + 2'd1);
    end
  end

  AST_EMPTY_BLOCKS_READ: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rptr_bin)); // R6
  AST_DOUT_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en_a_n || rd_en_b_n) |=> $stable(dout_q)); // R12
  AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $onehot0(rptr_gray ^ $past(rptr_gray))); // R7
  AST_AE_WHEN_EMPTY: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n); // R8
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
  import dcfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned DW   = DATA_W,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1,
  localparam int unsigned OW   = 2 * DW
) (
  input  logic          wr_clk,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en_n,
  input  logic          wen2_ld,
  output logic          full_n,
  output logic          almost_full_n,
  input  logic          rd_clk,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          oe_n,
  output wire  [DW-1:0] rd_data,
  output logic          rd_data_oe,
  output logic          empty_n,
  output logic          almost_empty_n,
  input  logic          rst_n
);
  logic          load_mode, wr_fire, load_fire;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wptr_gray, rptr_gray, wptr_sync, rptr_sync;
  logic [OW-1:0] ae_ofs, af_ofs;
  logic [DW-1:0] ram_q, dout_q;

  dcfifo_wr_ctl #(.DEPTH(DEPTH), .OW(OW)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wen2_ld(wen2_ld),
    .rptr_sync(rptr_sync), .af_ofs(af_ofs), .load_mode(load_mode),
    .wr_fire(wr_fire), .load_fire(load_fire), .waddr(waddr),
    .wptr_gray(wptr_gray), .full_n(full_n), .almost_full_n(almost_full_n)
  );

  dcfifo_ofs #(.DW(DW)) u_ofs (
    .wr_clk(wr_clk), .rst_n(rst_n), .load_fire(load_fire),
    .wr_data(wr_data), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  dcfifo_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .wr_clk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(ram_q)
  );

  dcfifo_gsync #(.W(PW)) u_w2r (
    .dst_clk(rd_clk), .rst_n(rst_n), .gray_in(wptr_gray), .bin_out(wptr_sync)
  );

  dcfifo_gsync #(.W(PW)) u_r2w (
    .dst_clk(wr_clk), .rst_n(rst_n), .gray_in(rptr_gray), .bin_out(rptr_sync)
  );

  dcfifo_rd_ctl #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en_a_n(rd_en_a_n),
    .rd_en_b_n(rd_en_b_n), .wen2_ld(wen2_ld), .wptr_sync(wptr_sync),
    .ram_q(ram_q), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .raddr(raddr),
    .rptr_gray(rptr_gray), .dout_q(dout_q), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n)
  );

  assign rd_data_oe = !oe_n;
  assign rd_data    = rd_data_oe ? dout_q : {DW{1'bz}};

  AST_LOAD_MODE_NO_DATA: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (load_mode && !wen2_ld) |-> !wr_fire); // R9
endmodule

// File: tb/sim_dcfifo_pflag.sv
module sim_dcfifo_pflag;
  localparam int unsigned DEPTH = 256;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] wr_data = '0;
  logic       wr_en_n = 1'b1, wen2_ld = 1'b1, rd_en_a_n = 1'b1, rd_en_b_n = 1'b1, oe_n = 1'b0;
  wire  [8:0] rd_data;
  logic       rd_data_oe, full_n, almost_full_n, empty_n, almost_empty_n;

  int unsigned n_checks = 0, n_fail = 0;
  bit          done = 1'b0;
  bit          load_mode = 1'b0;
  logic [8:0]  q [$];
  logic [17:0] m_ae = 18'd7, m_af = 18'd7;
  int unsigned wslot = 0, rslot = 0;
  logic [8:0]  last_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcfifo_pflag #(.DEPTH(DEPTH)) u0 (
    .wr_clk(clk), .wr_data(wr_data), .wr_en_n(wr_en_n), .wen2_ld(wen2_ld),
    .full_n(full_n), .almost_full_n(almost_full_n), .rd_clk(clk),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n), .oe_n(oe_n),
    .rd_data(rd_data), .rd_data_oe(rd_data_oe), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .rst_n(rst_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] slot_exp(input int unsigned s);
    case (s % 4)
      0: slot_exp = m_ae[8:0];
      1: slot_exp = m_ae[17:9];
      2: slot_exp = m_af[8:0];
      default: slot_exp = m_af[17:9];
    endcase
  endfunction

  // one cycle: inputs set at negedge, outputs sampled at the following negedge
  task automatic step(input bit w_n, input bit w2, input bit ra_n, input bit rb_n, input logic [8:0] d);
    bit acc_w, acc_r, ofs_w, rb;
    if (q.size() == DEPTH) check("R6 full flag at capacity", 32'(full_n), 32'd0);
    if (q.size() == 0) check("R6 empty flag when empty", 32'(empty_n), 32'd0);
    wr_en_n = w_n; wen2_ld = w2; rd_en_a_n = ra_n; rd_en_b_n = rb_n; wr_data = d;
    acc_w = !w_n && w2 && full_n;
    ofs_w = load_mode && !w_n && !w2;
    rb    = load_mode && !w2 && !ra_n && !rb_n;
    acc_r = !ra_n && !rb_n && !rb && empty_n;
    @(posedge clk);
    @(negedge clk);
    if (acc_w) q.push_back(d);
    if (ofs_w) begin
      case (wslot % 4)
        0: m_ae[8:0] = d;
        1: m_ae[17:9] = d;
        2: m_af[8:0] = d;
        default: m_af[17:9] = d;
      endcase
      wslot++;
    end
    if (acc_r) begin
      last_out = q.pop_front();
      check("R2 read data order", 32'(rd_data), 32'(last_out));
    end else if (rb) begin
      last_out = slot_exp(rslot);
      rslot++;
      check("R10 offset read-back slot", 32'(rd_data), 32'(last_out));
    end else begin
      check("R12 output holds", 32'(rd_data), 32'(last_out));
    end
    wr_en_n = 1'b1; wen2_ld = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
  endtask

  task automatic idle(input int unsigned n);
    for (int i = 0; i < int'(n); i++) step(1'b1, 1'b1, 1'b1, 1'b1, '0);
  endtask

  task automatic flags(input string req);
    int unsigned c;
    idle(3);
    c = q.size();
    check({req, " empty_n"}, 32'(empty_n), 32'(c != 0));
    check({req, " almost_empty_n"}, 32'(almost_empty_n), 32'(c > m_ae));
    check({req, " full_n"}, 32'(full_n), 32'(c != DEPTH));
    check({req, " almost_full_n"}, 32'(almost_full_n), 32'((DEPTH - c) > m_af));
  endtask

  task automatic wr(input logic [8:0] d);
    step(1'b0, 1'b1, 1'b1, 1'b1, d);
  endtask

  task automatic rd();
    step(1'b1, 1'b1, 1'b0, 1'b0, '0);
  endtask

  task automatic do_reset(input bit as_load);
    @(negedge clk);
    rst_n = 1'b0;
    wen2_ld = !as_load; wr_en_n = 1'b1; rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wen2_ld = 1'b1;
    load_mode = as_load;
    q.delete();
    m_ae = 18'd7; m_af = 18'd7; wslot = 0; rslot = 0; last_out = '0;
    check("R1 reset empty_n", 32'(empty_n), 32'd0);
    check("R1 reset almost_empty_n", 32'(almost_empty_n), 32'd0);
    check("R1 reset full_n", 32'(full_n), 32'd1);
    check("R1 reset almost_full_n", 32'(almost_full_n), 32'd1);
    check("R1 reset output register", 32'(rd_data), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'h5EED_0042);
    // ---- qualifier mode ----
    do_reset(1'b0);
    // R7: lag of empty_n behind a single write
    wr(9'h0A5);
    idle(1);
    check("R7 empty_n still low one cycle after write", 32'(empty_n), 32'd0);
    idle(1);
    check("R7 empty_n high two cycles after write", 32'(empty_n), 32'd1);
    rd();
    // R3: second qualifier low or first enable high blocks writes
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1, 1'b1, 9'(i + 1));
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b1, 9'(i + 9));
    flags("R3 ignored writes");
    // R5: a single read enable does nothing
    for (int i = 0; i < 3; i++) wr(9'(16'h40 + i));
    idle(3);
    step(1'b1, 1'b1, 1'b0, 1'b1, '0);
    step(1'b1, 1'b1, 1'b1, 1'b0, '0);
    check("R5 single enable keeps output", 32'(rd_data), 32'(last_out));
    flags("R5 single enable keeps count");
    while (q.size() != 0) rd();
    // R8 default thresholds
    for (int i = 0; i < 7; i++) wr(9'(i));
    flags("R8 seven stored");
    wr(9'h1FF);
    flags("R8 eight stored");
    while (q.size() < DEPTH - 8) wr(9'(q.size() * 3));
    flags("R8 eight free");
    wr(9'h155);
    flags("R8 seven free");
    while (full_n) wr(9'(q.size()));
    idle(1);
    for (int i = 0; i < 3; i++) wr(9'h0EE);
    flags("R6 writes dropped when full");
    // R11 output enable
    oe_n = 1'b1;
    #1;
    check("R11 output disabled", 32'(rd_data_oe), 32'd0);
    oe_n = 1'b0;
    #1;
    check("R11 output enabled", 32'(rd_data_oe), 32'd1);
    check("R11 driven value", 32'(rd_data), 32'(last_out));
    while (q.size() != 0) rd();
    idle(3);
    for (int i = 0; i < 3; i++) rd();
    flags("R6 reads dropped when empty");
    // random traffic, fill-biased then drain-biased
    for (int ph = 0; ph < 2; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        bit w, r;
        w = ($urandom % 100) < (ph == 0 ? 70 : 30);
        r = ($urandom % 100) < (ph == 0 ? 30 : 70);
        step(!w, ($urandom % 8) != 0, !r, !r, 9'($urandom));
      end
    end
    flags("R2 after random traffic");
    // ---- load mode ----
    do_reset(1'b1);
    // R4: writes with load strobe high store data
    for (int i = 0; i < 3; i++) wr(9'(16'h100 + i));
    flags("R4 load-mode data writes");
    // R9: two rounds of offset loading, wrapping the slot order
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'd5);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'd1);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'd3);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'd2);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'd10);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'd0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'd20);
    step(1'b0, 1'b0, 1'b1, 1'b1, 9'd0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0);
    check("R10 read-back kept contents", 32'(q.size()), 32'd3);
    rd();
    check("R10 first word after read-back", 32'(last_out), 32'h100);
    while (q.size() < 10) wr(9'(q.size()));
    flags("R9 count at almost-empty offset");
    wr(9'h033);
    flags("R9 count above almost-empty offset");
    while (q.size() < DEPTH - 21) wr(9'(q.size()));
    flags("R9 free above almost-full offset");
    wr(9'h0CC);
    flags("R9 free at almost-full offset");
    while (q.size() != 0) rd();
    flags("R2 load-mode drain");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule